// File: doc/BRIEF.md
# Store Buffer with Line-Push Slot

This block sits between a core that can issue one write per core clock and an external bus that runs at a fraction of that rate. Ordinary word stores are queued in a small FIFO, so the core stalls on a write only when that FIFO is full. A separate one-entry slot holds a whole evicted dirty line. The line is written back as a burst of word beats, and it never occupies a store entry.

The bus side advances only on core clock edges where the bus clock enable is high. Driving that enable every second or every fourth cycle therefore models a bus at one half or one quarter of core speed. An entry leaves the buffer only when the bus acknowledges it on an enabled edge. A line captured in the slot is written after the stores that were already queued when it was captured, and before any store accepted on or after that edge.

A read port probes the queued stores by word address and flags a hazard, so the core can hold a load until the matching store has left.

Both input streams use valid/ready. A store is taken on an edge where `st_valid` and `st_ready` are both high, and `st_ready` is low only while the FIFO is full. A line is taken on an edge where `ln_valid` and `ln_ready` are both high, and `ln_ready` is low while the slot is occupied. The bus side is a request/acknowledge pair qualified by `bus_ce`.

Top module: `store_write_buffer`

## Requirements
- R1: `st_ready` is low exactly when DEPTH (default 4) stores are held. Otherwise a store is accepted on every edge where `st_valid` is high.
- R2: Stores appear on the bus in acceptance order, with address, data and byte enables unchanged and `bus_line` low.
- R3: `ln_ready` is low from the edge that captures a line until the edge that completes its last beat. A line request made in that window is not taken.
- R4: A line is written as LINE_WORDS beats. Beat k has address (line address with its low log2(LINE_WORDS*4) bits cleared) + 4k, data `ln_data[32k+31:32k]`, byte enables all ones and `bus_line` high.
- R5: Stores held when a line is captured go to the bus before the line. Stores accepted on the capture edge or later go after the line's last beat.
- R6: A transfer completes only on an edge where `bus_ce`, `bus_ack` and `bus_req` are all high. An acknowledge with `bus_ce` low is ignored. While a request has not completed, `bus_req` and the bus address, data, byte enables and `bus_line` are held.
- R7: `rd_hazard` is high when `rd_valid` is high and some held store, including one in flight, has the same word address (bits 31:2) as `rd_addr`. It is low otherwise.
- R8: After reset, `st_ready` and `ln_ready` are high and `bus_req` and `rd_hazard` are low.
- R9: `bus_req` is low whenever no store and no line is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_valid | input | 1 | Store request valid |
| st_ready | output | 1 | Store FIFO can accept |
| st_addr | input | 32 | Store byte address |
| st_data | input | 32 | Store data |
| st_be | input | 4 | Store byte enables |
| ln_valid | input | 1 | Line push request valid |
| ln_ready | output | 1 | Line slot is free |
| ln_addr | input | 32 | Address within the evicted line |
| ln_data | input | 128 | Line contents, lowest word in the low bits |
| rd_valid | input | 1 | Read probe valid |
| rd_addr | input | 32 | Read probe address |
| rd_hazard | output | 1 | Read matches a queued store |
| bus_ce | input | 1 | Bus clock enable |
| bus_req | output | 1 | Bus transfer requested |
| bus_line | output | 1 | Current transfer is a line beat |
| bus_addr | output | 32 | Transfer address |
| bus_data | output | 32 | Transfer data |
| bus_be | output | 4 | Transfer byte enables |
| bus_ack | input | 1 | Bus acknowledge, taken only with bus_ce |

## Verification
A wrong occupancy count shows up as `st_ready` falling one store early or late, and a wrong read or write pointer puts the wrong address or data on the bus. Either fault is visible on the next cycle in which the affected entry reaches the head. A wrong line-ordering counter lets a store overtake the line, or keeps the line waiting. This shows in `bus_line` on the first cycle after the wrong entry is chosen. A stale hazard-valid bit leaves `rd_hazard` set after its store has drained, and this is visible on the very next probe of that word.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int BE_W   = DATA_W / 8;
  localparam logic [ADDR_W-1:0] WORD_MASK = ~ADDR_W'(BE_W - 1);

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
    logic [BE_W-1:0]   be;
  } st_entry_t;
endpackage

// File: rtl/wbuf_store_fifo.sv
module wbuf_store_fifo
  import wbuf_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  st_entry_t         push_entry,
  input  logic              pop,
  output st_entry_t         head,
  output logic              full,
  output logic              empty,
  output logic [CNT_W-1:0]  count,
  input  logic              probe_valid,
  input  logic [ADDR_W-1:0] probe_addr,
  output logic              probe_hit
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  st_entry_t          mem [DEPTH];
  logic [DEPTH-1:0]   held;
  logic [DEPTH-1:0]   hit_vec;
  logic [PTR_W-1:0]   wr_ptr, rd_ptr;
  logic [CNT_W-1:0]   cnt;

  function automatic logic [PTR_W-1:0] advance(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
      held   <= '0;
    end else begin
      if (pop) begin
        rd_ptr       <= advance(rd_ptr);
        held[rd_ptr] <= 1'b0;
      end
      if (push) begin
        wr_ptr       <= advance(wr_ptr);
        held[wr_ptr] <= 1'b1;
      end
      cnt <= cnt + CNT_W'(push) - CNT_W'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_entry;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_probe
    assign hit_vec[i] = held[i] &&
                        (((mem[i].addr ^ probe_addr) & WORD_MASK) == '0);
  end

  assign probe_hit = probe_valid && (|hit_vec);
  assign head      = mem[rd_ptr];
  assign count     = cnt;
  assign full      = (cnt == CNT_W'(DEPTH));
  assign empty     = (cnt == '0);

  assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  assert_no_underflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
  assert_count_tracks_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt == CNT_W'($countones(held)));
endmodule

// File: rtl/wbuf_line_slot.sv
module wbuf_line_slot
  import wbuf_pkg::*;
#(
  parameter int LINE_WORDS = 4,
  parameter int DEPTH      = 4,
  localparam int LINE_W    = LINE_WORDS * DATA_W,
  localparam int BEAT_W    = $clog2(LINE_WORDS),
  localparam int CNT_W     = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap,
  input  logic [ADDR_W-1:0] cap_addr,
  input  logic [LINE_W-1:0] cap_data,
  input  logic [CNT_W-1:0]  store_cnt,
  input  logic              store_done,
  input  logic              beat_done,
  output logic              busy,
  output logic              owns_bus,
  output logic [ADDR_W-1:0] beat_addr,
  output logic [DATA_W-1:0] beat_data
);
  localparam int LINE_BYTES = LINE_WORDS * BE_W;
  localparam logic [ADDR_W-1:0] LINE_MASK = ~ADDR_W'(LINE_BYTES - 1);

  logic              valid_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LINE_W-1:0] line_q;
  logic [BEAT_W-1:0] beat;
  logic [CNT_W-1:0]  ahead;
  logic              last_beat;

  assign last_beat = (beat == BEAT_W'(LINE_WORDS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      beat    <= '0;
      ahead   <= '0;
    end else if (cap) begin
      valid_q <= 1'b1;
      beat    <= '0;
      ahead   <= store_cnt - CNT_W'(store_done);
    end else begin
      if (valid_q && store_done && (ahead != '0)) ahead <= ahead - CNT_W'(1);
      if (beat_done) begin
        if (last_beat) begin
          valid_q <= 1'b0;
          beat    <= '0;
        end else begin
          beat <= beat + BEAT_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (cap) begin
      addr_q <= cap_addr;
      line_q <= cap_data;
    end
  end

  assign busy      = valid_q;
  assign owns_bus  = valid_q && (ahead == '0);
  assign beat_addr = (addr_q & LINE_MASK) | ADDR_W'({beat, 2'b00});
  assign beat_data = line_q[beat*DATA_W +: DATA_W];

  assert_no_recapture_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cap |-> !valid_q);
  assert_store_before_line_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && store_done) |-> (ahead != '0));
  assert_ahead_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> (ahead <= store_cnt));
  assert_beat_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !beat_done) |=> (valid_q && $stable(beat)));
endmodule

// File: rtl/wbuf_drain_mux.sv
module wbuf_drain_mux
  import wbuf_pkg::*;
(
  input  logic              line_owns,
  input  logic [ADDR_W-1:0] line_addr,
  input  logic [DATA_W-1:0] line_data,
  input  logic              fifo_empty,
  input  st_entry_t         fifo_head,
  output logic              req,
  output logic              is_line,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] data,
  output logic [BE_W-1:0]   be
);
  always_comb begin
    is_line = line_owns;
    req     = line_owns || !fifo_empty;
    if (line_owns) begin
      addr = line_addr;
      data = line_data;
      be   = '1;
    end else begin
      addr = fifo_head.addr;
      data = fifo_head.data;
      be   = fifo_head.be;
    end
  end
endmodule

// File: rtl/store_write_buffer.sv
module store_write_buffer
  import wbuf_pkg::*;
#(
  parameter int DEPTH      = 4,
  parameter int LINE_WORDS = 4,
  localparam int LINE_W    = LINE_WORDS * DATA_W,
  localparam int CNT_W     = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              st_valid,
  output logic              st_ready,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [DATA_W-1:0] st_data,
  input  logic [BE_W-1:0]   st_be,
  input  logic              ln_valid,
  output logic              ln_ready,
  input  logic [ADDR_W-1:0] ln_addr,
  input  logic [LINE_W-1:0] ln_data,
  input  logic              rd_valid,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_hazard,
  input  logic              bus_ce,
  output logic              bus_req,
  output logic              bus_line,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_data,
  output logic [BE_W-1:0]   bus_be,
  input  logic              bus_ack
);
  st_entry_t         new_entry, head;
  logic              fifo_full, fifo_empty;
  logic [CNT_W-1:0]  fifo_count;
  logic              st_take, ln_take;
  logic              xfer_done, store_done, beat_done;
  logic              line_busy, line_owns;
  logic [ADDR_W-1:0] line_addr;
  logic [DATA_W-1:0] line_data;

  assign new_entry = '{addr: st_addr, data: st_data, be: st_be};
  assign st_ready  = !fifo_full;
  assign ln_ready  = !line_busy;
  assign st_take   = st_valid && st_ready;
  assign ln_take   = ln_valid && ln_ready;
  assign xfer_done  = bus_ce && bus_ack && bus_req;
  assign store_done = xfer_done && !bus_line;
  assign beat_done  = xfer_done && bus_line;

  wbuf_store_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk         (clk),
    .rst_n       (rst_n),
    .push        (st_take),
    .push_entry  (new_entry),
    .pop         (store_done),
    .head        (head),
    .full        (fifo_full),
    .empty       (fifo_empty),
    .count       (fifo_count),
    .probe_valid (rd_valid),
    .probe_addr  (rd_addr),
    .probe_hit   (rd_hazard)
  );

  wbuf_line_slot #(.LINE_WORDS(LINE_WORDS), .DEPTH(DEPTH)) u_line (
    .clk        (clk),
    .rst_n      (rst_n),
    .cap        (ln_take),
    .cap_addr   (ln_addr),
    .cap_data   (ln_data),
    .store_cnt  (fifo_count),
    .store_done (store_done),
    .beat_done  (beat_done),
    .busy       (line_busy),
    .owns_bus   (line_owns),
    .beat_addr  (line_addr),
    .beat_data  (line_data)
  );

  wbuf_drain_mux u_mux (
    .line_owns  (line_owns),
    .line_addr  (line_addr),
    .line_data  (line_data),
    .fifo_empty (fifo_empty),
    .fifo_head  (head),
    .req        (bus_req),
    .is_line    (bus_line),
    .addr       (bus_addr),
    .data       (bus_data),
    .be         (bus_be)
  );

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_empty && !line_busy) |-> !bus_req);
  assert_request_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !(bus_ce && bus_ack)) |=>
      (bus_req && $stable(bus_addr) && $stable(bus_data) &&
       $stable(bus_be) && $stable(bus_line)));
  assert_hazard_needs_store_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hazard |-> (rd_valid && !fifo_empty));
  assert_line_beat_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_line) |-> (bus_be == '1));
endmodule

// File: tb/store_write_buffer_tb.sv
module store_write_buffer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 4;
  localparam int LW         = 4;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic          rst_n;
  logic          st_valid, st_ready;
  logic [31:0]   st_addr, st_data;
  logic [3:0]    st_be;
  logic          ln_valid, ln_ready;
  logic [31:0]   ln_addr;
  logic [LW*32-1:0] ln_data;
  logic          rd_valid, rd_hazard;
  logic [31:0]   rd_addr;
  logic          bus_ce, bus_req, bus_line, bus_ack;
  logic [31:0]   bus_addr, bus_data;
  logic [3:0]    bus_be;

  store_write_buffer #(.DEPTH(DEPTH), .LINE_WORDS(LW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr),
    .st_data(st_data), .st_be(st_be),
    .ln_valid(ln_valid), .ln_ready(ln_ready), .ln_addr(ln_addr), .ln_data(ln_data),
    .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_hazard(rd_hazard),
    .bus_ce(bus_ce), .bus_req(bus_req), .bus_line(bus_line),
    .bus_addr(bus_addr), .bus_data(bus_data), .bus_be(bus_be), .bus_ack(bus_ack)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  // reference model state
  logic [31:0] q_addr[$];
  logic [31:0] q_data[$];
  logic [3:0]  q_be[$];
  bit          lv = 0;
  logic [31:0] laddr;
  logic [31:0] ldata[LW];
  int          beat = 0;
  int          ahead = 0;
  bit          p_hold = 0;
  logic [31:0] p_addr, p_data;
  logic [3:0]  p_be;
  logic        p_line;

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  task automatic step(input int st_p, input int ln_p, input int ack_p,
                      input int ce_mode, input int rd_p);
    bit          req_line, req, hz, done_x, sdone, bdone, st_take, ln_take;
    logic [31:0] e_addr, e_data;
    logic [3:0]  e_be;
    int          size_before;
    @(negedge clk);
    st_valid = (($urandom % 100) < st_p);
    st_addr  = 32'h1000 + 4 * ($urandom % 8);
    st_data  = $urandom;
    st_be    = 4'(($urandom % 15) + 1);
    ln_valid = (($urandom % 100) < ln_p);
    ln_addr  = 32'h2000 + ($urandom % 64);
    ln_data  = {$urandom, $urandom, $urandom, $urandom};
    bus_ack  = (($urandom % 100) < ack_p);
    case (ce_mode)
      0: bus_ce = 1'b1;
      1: bus_ce = (cyc % 2 == 0);
      2: bus_ce = (cyc % 4 == 0);
      default: bus_ce = 1'b0;
    endcase
    rd_valid = (($urandom % 100) < rd_p);
    rd_addr  = 32'h1000 + 4 * ($urandom % 8) + ($urandom % 4);
    #1;
    // expected outputs from the model
    req_line = lv && (ahead == 0);
    req      = req_line || (q_addr.size() > 0);
    if (req_line) begin
      e_addr = {laddr[31:4], 4'b0000} + 32'(4 * beat);
      e_data = ldata[beat];
      e_be   = 4'hF;
    end else if (req) begin
      e_addr = q_addr[0];
      e_data = q_data[0];
      e_be   = q_be[0];
    end
    hz = 0;
    if (rd_valid)
      foreach (q_addr[i]) if (q_addr[i][31:2] == rd_addr[31:2]) hz = 1;

    chk("R1", "st_ready", 32'(st_ready), 32'(q_addr.size() < DEPTH));
    chk("R3", "ln_ready", 32'(ln_ready), 32'(!lv));
    chk("R9", "bus_req", 32'(bus_req), 32'(req));
    chk("R7", "rd_hazard", 32'(rd_hazard), 32'(hz));
    if (req) begin
      chk("R5", "bus_line", 32'(bus_line), 32'(req_line));
      if (req_line) begin
        chk("R4", "line beat addr", bus_addr, e_addr);
        chk("R4", "line beat data", bus_data, e_data);
        chk("R4", "line beat be", 32'(bus_be), 32'(e_be));
      end else begin
        chk("R2", "store addr", bus_addr, e_addr);
        chk("R2", "store data", bus_data, e_data);
        chk("R2", "store be", 32'(bus_be), 32'(e_be));
      end
    end
    if (p_hold) begin
      chk("R6", "held req", 32'(bus_req), 32'd1);
      chk("R6", "held addr", bus_addr, p_addr);
      chk("R6", "held data", bus_data, p_data);
      chk("R6", "held be/line", {27'd0, bus_line, bus_be}, {27'd0, p_line, p_be});
    end

    // advance the model to the next edge
    done_x  = bus_ce && bus_ack && req;
    sdone   = done_x && !req_line;
    bdone   = done_x && req_line;
    st_take = st_valid && (q_addr.size() < DEPTH);
    ln_take = ln_valid && !lv;
    p_hold  = req && !(bus_ce && bus_ack);
    p_addr  = e_addr; p_data = e_data; p_be = e_be; p_line = req_line;
    size_before = q_addr.size();
    if (ln_take) begin
      lv    = 1;
      laddr = ln_addr;
      for (int k = 0; k < LW; k++) ldata[k] = ln_data[k*32 +: 32];
      beat  = 0;
      ahead = size_before - (sdone ? 1 : 0);
    end else begin
      if (lv && sdone && ahead > 0) ahead--;
      if (bdone) begin
        if (beat == LW - 1) begin lv = 0; beat = 0; end
        else beat++;
      end
    end
    if (sdone) begin
      void'(q_addr.pop_front()); void'(q_data.pop_front()); void'(q_be.pop_front());
    end
    if (st_take) begin
      q_addr.push_back(st_addr); q_data.push_back(st_data); q_be.push_back(st_be);
    end
    cyc++;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    st_valid = 0; st_addr = 0; st_data = 0; st_be = 0;
    ln_valid = 0; ln_addr = 0; ln_data = '0;
    bus_ce = 0; bus_ack = 0;
    rd_valid = 1; rd_addr = 32'h1000;
    repeat (3) @(negedge clk);
    #1;
    // R8: reset state
    chk("R8", "reset st_ready", 32'(st_ready), 32'd1);
    chk("R8", "reset ln_ready", 32'(ln_ready), 32'd1);
    chk("R8", "reset bus_req", 32'(bus_req), 32'd0);
    chk("R8", "reset rd_hazard", 32'(rd_hazard), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: fill the FIFO with the bus stopped, then keep pushing
    for (int i = 0; i < 7; i++) step(100, 0, 100, 3, 60);
    // R5: a line captured behind four stores; R3: a second line is refused
    for (int i = 0; i < 4; i++) step(0, 100, 100, 3, 60);
    // R6: acks with the enable low are ignored, then half-rate drain
    for (int i = 0; i < 4; i++) step(0, 0, 100, 3, 60);
    for (int i = 0; i < 40; i++) step(30, 0, 100, 1, 60);
    // line captured into an empty FIFO with a store on the same edge
    for (int i = 0; i < 2; i++) step(100, 100, 0, 3, 60);
    for (int i = 0; i < 30; i++) step(0, 0, 100, 0, 60);
    // mixed traffic at every bus rate
    for (int i = 0; i < 800; i++) step(60, 10, 70, 0, 50);
    for (int i = 0; i < 800; i++) step(50, 10, 80, 1, 50);
    for (int i = 0; i < 800; i++) step(40, 8, 90, 2, 50);
    for (int i = 0; i < 600; i++) step(90, 20, 50, 1, 70);
    for (int i = 0; i < 60; i++) step(0, 0, 100, 0, 50);
    done = 1;
    summary();
    $finish;
  end
endmodule